// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of a single read or write burst inside one bank of a synchronous DRAM controller. A start request carries a start column, a burst length code and a wrap order. From the rising edge that captures the start, the block emits one column per clock. Each column comes with a valid flag and a flag that marks the final beat.

Two wrap orders are supported. In sequential order the low bits count upward within an aligned group. In interleaved order the start column is XOR-ed with the beat index. A full-page length runs around the whole 8-bit page until something ends it. A stop request cuts a burst short. A new start may arrive on any cycle and replaces whatever burst is running. Row activation, latency delay and the data path are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are low and `col_o` is zero.
- R2: A legal start seen at a rising edge makes `valid_o` high after that edge, with `col_o` equal to the start column (beat 0).
- R3: The length code `len_code_i` selects the burst length: 0 selects 1 beat, 1 selects 2, 2 selects 4, 3 selects 8, and 7 selects full page. A burst of length L holds `valid_o` high for exactly L consecutive cycles, then drops it.
- R4: With `order_i`=0 (sequential), beat n has its low log2(L) bits equal to (start + n) mod L. The upper bits equal those of the start column.
- R5: With `order_i`=1 (interleaved), beat n has its low log2(L) bits equal to the start column's low bits XOR n. The upper bits are unchanged.
- R6: `last_o` is high on the final beat of a finite burst and on no other beat.
- R7: A full-page sequential burst steps through all 256 columns, wraps from 255 to 0, and keeps running. It never raises `last_o`.
- R8: A stop request (`stop_i`) without a start clears `valid_o` at the next edge. When no burst is active, a stop request has no effect.
- R9: A start request replaces any burst in progress at that edge. When `start_i` and `stop_i` are both high, the start wins.
- R10: A start with an illegal mode gives no beats. Illegal modes are interleaved order with full page, and length codes 4 to 6. After that edge `err_o` is high and `valid_o` is low, and any running burst is ended.
- R11: `err_o` is high for only the one cycle after an illegal start. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new burst this cycle |
| stop_i | input | 1 | Terminate the running burst |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| valid_o | output | 1 | `col_o` holds a burst beat |
| col_o | output | COL_W | Current column address |
| last_o | output | 1 | Final beat of a finite burst |
| err_o | output | 1 | Illegal mode requested at the last start |

## Verification
The assertions assume three things about the inputs:
- The length code, order and start column only matter in a cycle where `start_i` is high. Their values at other times are ignored.
- `start_i` and `stop_i` are settled before each rising edge.
- `start_i` and `stop_i` may be high in the same cycle.

The stimulus respects this. It changes every input on the falling edge, and it raises the mode inputs only together with a start. This includes back-to-back and overlapping commands, and starts with illegal modes, both when idle and during a running burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'd7;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  typedef struct packed {
    logic       full;
    logic       bad;
    logic [1:0] lg;
  } mode_t;
endpackage

// File: rtl/burst_col_decode.sv
module burst_col_decode
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  order_e                order_i,
  output mode_t                 mode_o,
  output logic [COL_W-1:0]      mask_o
);
  logic full;
  logic [1:0] lg;

  assign full = (len_code_i == LEN_PAGE);
  assign lg   = len_code_i[1:0];

  assign mode_o.full = full;
  assign mode_o.lg   = lg;
  // codes 4..6 reserved; full page only in sequential order
  assign mode_o.bad  = (len_code_i[2] & ~full) | (full & (order_i == ORD_ILV));

  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_o[b] = full | (32'(lg) > b);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  always_comb begin
    if (order_i == ORD_ILV) low = base_i ^ beat_i;
    else                    low = base_i + beat_i;
    col_o = (base_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  mode_t            mode_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] gen_base_o,
  output logic [COL_W-1:0] gen_beat_o,
  output logic [COL_W-1:0] gen_mask_o,
  output order_e           gen_order_o,
  input  logic [COL_W-1:0] gen_col_i,
  output logic             valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o,
  output logic             err_o
);
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  order_e           order_q;
  logic             full_q;
  logic             full_sel;
  logic             advance;

  assign advance = valid_o & ~stop_i & ~last_o;

  always_comb begin
    if (start_i) begin
      gen_base_o  = start_col_i;
      gen_beat_o  = '0;
      gen_mask_o  = mask_i;
      gen_order_o = order_i;
      full_sel    = mode_i.full;
    end else begin
      gen_base_o  = base_q;
      gen_beat_o  = beat_q + 1'b1;
      gen_mask_o  = mask_q;
      gen_order_o = order_q;
      full_sel    = full_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      order_q <= ORD_SEQ;
      full_q  <= 1'b0;
      valid_o <= 1'b0;
      col_o   <= '0;
      last_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      err_o <= start_i & mode_i.bad;
      if (start_i && mode_i.bad) begin
        valid_o <= 1'b0;
        last_o  <= 1'b0;
      end else if (start_i || advance) begin
        base_q  <= gen_base_o;
        beat_q  <= gen_beat_o;
        mask_q  <= gen_mask_o;
        order_q <= gen_order_o;
        full_q  <= full_sel;
        valid_o <= 1'b1;
        col_o   <= gen_col_i;
        last_o  <= ~full_sel & (gen_beat_o == gen_mask_o);
      end else begin
        valid_o <= 1'b0;
        last_o  <= 1'b0;
      end
    end
  end

  p_start_col_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !mode_i.bad |=> valid_o && col_o == $past(start_col_i));

  p_upper_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !start_i && !stop_i && !last_o |=>
      valid_o && ((col_o & ~mask_q) == ($past(col_o) & ~$past(mask_q))));

  p_end_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && last_o && !start_i |=> !valid_o);

  p_page_no_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_q |-> !last_o);

  p_stop_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !valid_o);

  p_bad_no_beat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i.bad |=> err_o && !valid_o);

  p_err_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && mode_i.bad) |=> !err_o);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             order_i,
  output logic             valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o,
  output logic             err_o
);
  mode_t            mode;
  logic [COL_W-1:0] mask;
  order_e           order_in;
  logic [COL_W-1:0] g_base, g_beat, g_mask, g_col;
  order_e           g_order;

  assign order_in = order_e'(order_i);

  burst_col_decode #(.COL_W(COL_W)) i_decode (
    .len_code_i (len_code_i),
    .order_i    (order_in),
    .mode_o     (mode),
    .mask_o     (mask)
  );

  burst_col_gen #(.COL_W(COL_W)) i_gen (
    .base_i  (g_base),
    .beat_i  (g_beat),
    .mask_i  (g_mask),
    .order_i (g_order),
    .col_o   (g_col)
  );

  burst_col_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .mode_i      (mode),
    .mask_i      (mask),
    .order_i     (order_in),
    .gen_base_o  (g_base),
    .gen_beat_o  (g_beat),
    .gen_mask_o  (g_mask),
    .gen_order_o (g_order),
    .gen_col_i   (g_col),
    .valid_o     (valid_o),
    .col_o       (col_o),
    .last_o      (last_o),
    .err_o       (err_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |=> !valid_o && !err_o && !last_o);

  p_start_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && stop_i && !mode.bad |=> valid_o);
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 8;
  localparam int NVEC = 12;
  // {len_code[2:0], order, start_col[7:0]}
  localparam logic [11:0] VECS [NVEC] = '{
    {3'd0, 1'b0, 8'h35}, {3'd1, 1'b0, 8'h35}, {3'd2, 1'b0, 8'h36},
    {3'd3, 1'b0, 8'h3D}, {3'd1, 1'b1, 8'h35}, {3'd2, 1'b1, 8'h36},
    {3'd3, 1'b1, 8'h3D}, {3'd3, 1'b0, 8'hFE}, {3'd3, 1'b1, 8'h07},
    {3'd0, 1'b1, 8'hA0}, {3'd2, 1'b0, 8'hFF}, {3'd3, 1'b1, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, order_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic valid_o, last_o, err_o;
  logic [COL_W-1:0] col_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .start_col_i(start_col_i), .len_code_i(len_code_i), .order_i(order_i),
    .valid_o(valid_o), .col_o(col_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_of(input logic [2:0] code);
    return (code == 3'd7) ? 256 : (1 << code);
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] base, input int n, input int len, input logic ilv);
    logic [7:0] m, lo;
    m  = 8'(len - 1);
    lo = ilv ? (base ^ 8'(n)) : 8'(base + 8'(n));
    return (base & ~m) | (lo & m);
  endfunction

  task automatic launch(input logic [2:0] code, input logic ilv, input logic [7:0] col, input logic stp);
    @(negedge clk);
    start_i = 1'b1; stop_i = stp; len_code_i = code; order_i = ilv; start_col_i = col;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  // beat check: R2 beat 0, R4/R5 order, R6 last flag, R7 page
  task automatic beat(input logic [7:0] base, input int n, input int len, input logic ilv, input string req);
    logic [9:0] e, a;
    e = {1'b1, (len != 256) && (n == len - 1), exp_col(base, n, len, ilv)};
    a = {valid_o, last_o, col_o};
    chk(a == e, req, 32'(a), 32'(e));
  endtask

  task automatic idle(input string req);
    chk(!valid_o && !last_o, req, {30'd0, valid_o, last_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk({valid_o, last_o, err_o, col_o} == '0, "R1 reset", 32'({valid_o, last_o, err_o, col_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({valid_o, last_o, err_o} == '0, "R1 after release", 32'({valid_o, last_o, err_o}), 0);

    // table: R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] code;
      logic ilv;
      logic [7:0] base;
      int len;
      {code, ilv, base} = VECS[v];
      len = len_of(code);
      launch(code, ilv, base, 1'b0);
      for (int n = 0; n < len; n++) begin
        if (n > 0) @(negedge clk);
        beat(base, n, len, ilv, ilv ? "R5 interleave beat" : "R4 sequential beat");
      end
      @(negedge clk);
      idle("R3 burst length end");
    end

    // R7 full page: wraps and never ends by itself
    launch(3'd7, 1'b0, 8'hC3, 1'b0);
    for (int n = 0; n < 260; n++) begin
      if (n > 0) @(negedge clk);
      beat(8'hC3, n % 256, 256, 1'b0, "R7 full page");
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    idle("R8 stop full page");

    // R8 stop mid burst, then stop while idle
    launch(3'd3, 1'b0, 8'h10, 1'b0);
    for (int n = 0; n < 3; n++) begin
      if (n > 0) @(negedge clk);
      beat(8'h10, n, 8, 1'b0, "R8 pre-stop beat");
    end
    stop_i = 1'b1;
    @(negedge clk);
    idle("R8 stop mid burst");
    @(negedge clk);
    stop_i = 1'b0;
    idle("R8 stop while idle");
    chk(!err_o, "R11 err low after stop", 32'(err_o), 0);

    // R9 start replaces running burst, with stop in the same cycle
    launch(3'd3, 1'b0, 8'h20, 1'b0);
    beat(8'h20, 0, 8, 1'b0, "R9 old beat 0");
    @(negedge clk);
    beat(8'h20, 1, 8, 1'b0, "R9 old beat 1");
    start_i = 1'b1; stop_i = 1'b1; len_code_i = 3'd2; order_i = 1'b1; start_col_i = 8'h45;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      if (n > 0) @(negedge clk);
      beat(8'h45, n, 4, 1'b1, "R9 replacement beat");
    end
    @(negedge clk);
    idle("R9 replacement end");

    // R10 illegal interleave + full page while idle
    launch(3'd7, 1'b1, 8'h00, 1'b0);
    chk(err_o && !valid_o, "R10 ilv page", 32'({err_o, valid_o}), 32'h2);
    @(negedge clk);
    chk(!err_o && !valid_o, "R11 err pulse", 32'({err_o, valid_o}), 0);

    // R10 reserved code during a running burst
    launch(3'd3, 1'b0, 8'h80, 1'b0);
    beat(8'h80, 0, 8, 1'b0, "R10 pre beat");
    launch(3'd5, 1'b0, 8'h11, 1'b0);
    chk(err_o && !valid_o, "R10 reserved code", 32'({err_o, valid_o}), 32'h2);
    @(negedge clk);
    chk(!err_o && !valid_o, "R11 err clear", 32'({err_o, valid_o}), 0);

    // R10 full page in sequential order is legal
    launch(3'd7, 1'b0, 8'h01, 1'b0);
    chk(!err_o, "R10 seq page legal", 32'(err_o), 0);
    beat(8'h01, 0, 256, 1'b0, "R7 page start");
    launch(3'd0, 1'b0, 8'h02, 1'b0);
    beat(8'h02, 0, 1, 1'b0, "R9 replace page");

    // R1 asynchronous reset mid burst
    launch(3'd3, 1'b1, 8'h33, 1'b0);
    #1 rst_ni = 1'b0;
    #1 chk({valid_o, last_o, err_o, col_o} == '0, "R1 async reset", 32'({valid_o, col_o}), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule